// File: doc/BRIEF.md
# Chained Static Seven-Segment Digit Updater

This block refreshes twelve statically driven seven-segment digits. Each digit has its own latching shift register. The registers form a serial chain, split into four groups of three. Each group has its own latch strobe line. The host presents twelve 4-bit digit codes, a decimal-point bit per digit and a few configuration inputs, then pulses a request. The block takes a snapshot of everything at that moment. It turns each code into a segment byte and shifts the bytes out on a serial clock and data pair. After the last bit of a sequence it pulses the strobe, so the registers copy their shifted contents to the display outputs.

There are two refresh schemes. In full-chain mode all twelve bytes go out back to back, and then every strobe line pulses together, acting as one shared strobe. In group mode each selected group gets its own three-byte sequence, and only that group's strobe pulses. Groups left out of the enable mask receive no strobe and keep what they show. A separate input sets whether each sequence starts from its lowest-numbered digit or its highest, to suit how the chain is wired.

Top module: `seg_chain_updater`

## Requirements
- R1: While reset is held and in idle, busy_o, sclk_o, sdata_o and every strobe line are 0.
- R2: Segment byte bit 0..6 = segments a..g, bit 7 = decimal point taken from dp_i of that digit; codes 0..9 give 3F,06,5B,4F,66,6D,7D,07,7F,6F in the low seven bits and codes 10..15 give all segments off.
- R3: Each byte is sent MSB first; sclk_o idles low, and sdata_o is set during the low phase and stays unchanged across the rising edge; each bit takes SCK_HALF cycles low then SCK_HALF cycles high.
- R4: With group_mode_i = 0, one sequence of 96 bits is sent, then all four strobe lines pulse together once.
- R5: With group_mode_i = 1, each group whose group_en_i bit is set receives its own 24-bit sequence, in ascending group order, and after each sequence only that group's strobe line pulses.
- R6: In group mode a group whose enable bit is clear gets no strobe and its displayed digits keep their previous content; a zero mask produces no strobe at all.
- R7: Digit k is digits_i[4k+3:4k] with dp_i[k]; group g holds digits 3g..3g+2. With lsd_first_i = 1 a sequence starts at its lowest-numbered digit, otherwise at its highest.
- R8: A strobe rises only after the final bit of its sequence has been clocked, and sclk_o stays low while any strobe is high.
- R9: busy_o rises the cycle after an accepted request and falls once the last strobe is released. A busy period lasts 1 + 192*SCK_HALF + STROBE_LEN cycles in full-chain mode and 4 + n*(48*SCK_HALF + STROBE_LEN) cycles in group mode with n enabled groups. Requests and input changes while busy have no effect.
- R10: Each strobe pulse stays high for STROBE_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Update request, taken when idle |
| group_mode_i | input | 1 | 0: full chain, 1: per-group refresh |
| lsd_first_i | input | 1 | 1: lowest-numbered digit of a sequence first |
| group_en_i | input | 4 | Groups to refresh in group mode |
| digits_i | input | 48 | Twelve 4-bit digit codes, digit k at bits 4k+3:4k |
| dp_i | input | 12 | Decimal point per digit |
| busy_o | output | 1 | Update in progress |
| sclk_o | output | 1 | Serial shift clock to the chain |
| sdata_o | output | 1 | Serial data to the chain |
| strobe_o | output | 4 | Latch strobe, one line per group |

## Verification
Two functions can meet in the same cycle. A new request can arrive while a refresh is still shifting or strobing. The last serial clock of one group's sequence can also sit right next to the strobe that closes it, and to the first clock of the next group. The bench fires a second request mid-transfer with different digit codes and expects the latched result and the busy length to match the first request only. A chain model clocks sdata_o on every sclk_o rising edge and checks the bit count when each strobe rises. A strobe that is early, late or overlapping shows up as a wrong count, a wrong byte or a wrong strobe pattern. Masks 0 to 15 are swept in both digit orders, and full-chain runs use rotating code patterns that cover all sixteen codes.

// File: rtl/seg_chain_pkg.sv
package seg_chain_pkg;

  typedef logic [7:0] seg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SHIFT,
    ST_STROBE
  } upd_state_e;

  // bit0..6 = a..g, bit7 = decimal point
  function automatic seg_t seg_encode(input logic [3:0] code, input logic dp);
    logic [6:0] glyph;
    case (code)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
    return {dp, glyph};
  endfunction

endpackage

// File: rtl/seg_digit_decode.sv
module seg_digit_decode
  import seg_chain_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       dp_i,
  output seg_t       seg_o
);

  assign seg_o = seg_encode(code_i, dp_i);

endmodule

// File: rtl/seg_bit_shifter.sv
module seg_bit_shifter #(
  parameter int unsigned SCK_HALF = 1,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              byte_done_o
);

  localparam int unsigned PH_N  = 2 * SCK_HALF;
  localparam int unsigned PH_W  = (PH_N > 1) ? $clog2(PH_N) : 1;
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;
  logic             ph_last;

  assign ph_last = (ph_q == PH_W'(PH_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      bit_q <= BIT_W'(BYTE_W - 1);
    end else if (!run_i) begin
      ph_q  <= '0;
      bit_q <= BIT_W'(BYTE_W - 1);
    end else if (ph_last) begin
      ph_q  <= '0;
      bit_q <= (bit_q == '0) ? BIT_W'(BYTE_W - 1) : bit_q - 1'b1;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  // low half: data settles; high half: chain samples on the rise
  assign sclk_o      = run_i && (ph_q >= PH_W'(SCK_HALF));
  assign sdata_o     = run_i && byte_i[bit_q];
  assign byte_done_o = run_i && ph_last && (bit_q == '0);

endmodule

// File: rtl/seg_chain_updater.sv
module seg_chain_updater
  import seg_chain_pkg::*;
#(
  parameter int unsigned N_GROUPS     = 4,
  parameter int unsigned GROUP_DIGITS = 3,
  parameter int unsigned SCK_HALF     = 1,
  parameter int unsigned STROBE_LEN   = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic                                group_mode_i,
  input  logic                                lsd_first_i,
  input  logic [N_GROUPS-1:0]                 group_en_i,
  input  logic [4*N_GROUPS*GROUP_DIGITS-1:0]  digits_i,
  input  logic [N_GROUPS*GROUP_DIGITS-1:0]    dp_i,
  output logic                                busy_o,
  output logic                                sclk_o,
  output logic                                sdata_o,
  output logic [N_GROUPS-1:0]                 strobe_o
);

  localparam int unsigned N_DIGITS = N_GROUPS * GROUP_DIGITS;
  localparam int unsigned DIG_W    = $clog2(N_DIGITS);
  localparam int unsigned GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam int unsigned STB_W    = (STROBE_LEN > 1) ? $clog2(STROBE_LEN) : 1;

  upd_state_e           state_q;
  seg_t                 seg_q [N_DIGITS];
  seg_t                 dec_w [N_DIGITS];
  logic [GRP_W-1:0]     grp_q;
  logic [DIG_W-1:0]     pos_q;
  logic [DIG_W-1:0]     dig_idx;
  logic [STB_W-1:0]     stb_cnt_q;
  logic                 mode_q, lsd_q;
  logic [N_GROUPS-1:0]  en_q;
  logic                 byte_done;
  logic                 seq_last;
  logic                 grp_last;
  int                   last_pos;

  for (genvar k = 0; k < N_DIGITS; k++) begin : g_dec
    seg_digit_decode u_dec (
      .code_i (digits_i[4*k +: 4]),
      .dp_i   (dp_i[k]),
      .seg_o  (dec_w[k])
    );
  end

  always_comb begin
    int base;
    int off;
    last_pos = mode_q ? int'(GROUP_DIGITS) - 1 : int'(N_DIGITS) - 1;
    base     = mode_q ? int'(grp_q) * int'(GROUP_DIGITS) : 0;
    off      = lsd_q ? int'(pos_q) : last_pos - int'(pos_q);
    dig_idx  = DIG_W'(base + off);
  end

  assign seq_last = (pos_q == DIG_W'(last_pos));
  assign grp_last = (grp_q == GRP_W'(N_GROUPS - 1));

  seg_bit_shifter #(
    .SCK_HALF (SCK_HALF),
    .BYTE_W   (8)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (state_q == ST_SHIFT),
    .byte_i      (seg_q[dig_idx]),
    .sclk_o      (sclk_o),
    .sdata_o     (sdata_o),
    .byte_done_o (byte_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      grp_q     <= '0;
      pos_q     <= '0;
      stb_cnt_q <= '0;
      mode_q    <= 1'b0;
      lsd_q     <= 1'b0;
      en_q      <= '0;
      for (int k = 0; k < N_DIGITS; k++) seg_q[k] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          // snapshot: later input changes cannot disturb the transfer
          for (int k = 0; k < N_DIGITS; k++) seg_q[k] <= dec_w[k];
          mode_q  <= group_mode_i;
          lsd_q   <= lsd_first_i;
          en_q    <= group_en_i;
          grp_q   <= '0;
          pos_q   <= '0;
          state_q <= ST_SELECT;
        end
        ST_SELECT: begin
          if (!mode_q || en_q[grp_q]) begin
            pos_q   <= '0;
            state_q <= ST_SHIFT;
          end else if (grp_last) begin
            state_q <= ST_IDLE;
          end else begin
            grp_q   <= grp_q + 1'b1;
          end
        end
        ST_SHIFT: if (byte_done) begin
          if (seq_last) begin
            stb_cnt_q <= '0;
            state_q   <= ST_STROBE;
          end else begin
            pos_q     <= pos_q + 1'b1;
          end
        end
        ST_STROBE: begin
          if (stb_cnt_q == STB_W'(STROBE_LEN - 1)) begin
            if (!mode_q || grp_last) begin
              state_q <= ST_IDLE;
            end else begin
              grp_q   <= grp_q + 1'b1;
              state_q <= ST_SELECT;
            end
          end else begin
            stb_cnt_q <= stb_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int g = 0; g < N_GROUPS; g++) begin
      strobe_o[g] = (state_q == ST_STROBE) && (!mode_q || grp_q == GRP_W'(g));
    end
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/seg_chain_checker.sv
module seg_chain_checker #(
  parameter int unsigned N_GROUPS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_o,
  input logic                sclk_o,
  input logic                sdata_o,
  input logic [N_GROUPS-1:0] strobe_o
);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sdata_o && strobe_o == '0));

  a_r9_request_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r9_strobe_within_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> busy_o);

  a_r8_no_clock_under_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> !sclk_o);

  a_r5_strobe_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> ($onehot0(strobe_o) || (&strobe_o)));

  a_r3_data_held_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdata_o));

endmodule

bind seg_chain_updater seg_chain_checker #(.N_GROUPS(N_GROUPS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .strobe_o (strobe_o)
);

// File: tb/seg_chain_updater_tb.sv
module seg_chain_updater_tb;

  localparam int CLK_PERIOD   = 10;
  localparam int N_GROUPS     = 4;
  localparam int GROUP_DIGITS = 3;
  localparam int N_DIGITS     = 12;
  localparam int SCK_HALF     = 1;
  localparam int STROBE_LEN   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        group_mode = 1'b0;
  logic        lsd_first = 1'b0;
  logic [3:0]  group_en = '0;
  logic [47:0] digits = '0;
  logic [11:0] dp = '0;
  logic        busy, sclk, sdata;
  logic [3:0]  strobe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [47:0] acc_digits = '0;
  logic [11:0] acc_dp = '0;
  logic        acc_mode = 1'b0;
  logic        acc_lsd = 1'b0;
  logic [7:0]  ref_disp [N_DIGITS];
  logic [7:0]  mon_disp [N_DIGITS];
  logic [3:0]  exp_stb [N_GROUPS];
  int          exp_n = 0;
  int          stb_idx = 0;
  logic [95:0] rx = '0;
  int          rx_cnt = 0;
  int          busy_cycles = 0;
  int          stb_len = 0;
  logic        prev_sclk = 1'b0;
  logic        prev_stb = 1'b0;

  seg_chain_updater #(
    .N_GROUPS     (N_GROUPS),
    .GROUP_DIGITS (GROUP_DIGITS),
    .SCK_HALF     (SCK_HALF),
    .STROBE_LEN   (STROBE_LEN)
  ) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .group_mode_i (group_mode),
    .lsd_first_i  (lsd_first),
    .group_en_i   (group_en),
    .digits_i     (digits),
    .dp_i         (dp),
    .busy_o       (busy),
    .sclk_o       (sclk),
    .sdata_o      (sdata),
    .strobe_o     (strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_seg(input logic [3:0] c, input logic d);
    logic [6:0] s;
    case (c)
      4'd0: s = 7'h3F; 4'd1: s = 7'h06; 4'd2: s = 7'h5B; 4'd3: s = 7'h4F;
      4'd4: s = 7'h66; 4'd5: s = 7'h6D; 4'd6: s = 7'h7D; 4'd7: s = 7'h07;
      4'd8: s = 7'h7F; 4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return {d, s};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // chain model: clock data on sclk rise, evaluate on strobe rise
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (busy) busy_cycles++;
      if (sclk && !prev_sclk) begin
        rx = {rx[94:0], sdata};
        rx_cnt++;
      end
      if (strobe != 4'h0) stb_len++;
      if (strobe != 4'h0 && !prev_stb) begin
        int nb;
        int base;
        nb = acc_mode ? GROUP_DIGITS : N_DIGITS;
        base = 0;
        if (acc_mode)
          for (int g = 0; g < N_GROUPS; g++) if (strobe[g]) base = g * GROUP_DIGITS;
        check(stb_idx < exp_n && strobe == exp_stb[stb_idx], "R4/R5", "strobe pattern",
              strobe, (stb_idx < exp_n) ? exp_stb[stb_idx] : 4'h0);
        check(rx_cnt == nb * 8, "R8", "bits before strobe", rx_cnt, nb * 8);
        for (int p = 0; p < nb; p++) begin
          int d;
          logic [7:0] got, want;
          d = base + (acc_lsd ? p : nb - 1 - p);
          got = rx[(nb-1-p)*8 +: 8];
          want = ref_seg(acc_digits[4*d +: 4], acc_dp[d]);
          check(got == want, "R2/R3/R7", "byte in sequence", got, want);
          mon_disp[d] = got;
        end
        rx_cnt = 0;
        stb_idx++;
      end
      if (strobe == 4'h0 && prev_stb) begin
        check(stb_len == STROBE_LEN, "R10", "strobe width", stb_len, STROBE_LEN);
        stb_len = 0;
        if (!acc_mode) check(!busy, "R9", "busy after final strobe", busy, 0);
      end
      prev_sclk = sclk;
      prev_stb  = (strobe != 4'h0);
    end
  end

  task automatic run(input logic mode, input logic lsd, input logic [3:0] mask,
                     input logic [47:0] dig, input logic [11:0] dpv, input bit poke);
    int exp_busy;
    int n_en;
    @(negedge clk);
    group_mode = mode; lsd_first = lsd; group_en = mask; digits = dig; dp = dpv;
    start = 1'b1;
    acc_mode = mode; acc_lsd = lsd; acc_digits = dig; acc_dp = dpv;
    exp_n = 0; stb_idx = 0; rx_cnt = 0; busy_cycles = 0; n_en = 0;
    if (!mode) begin
      exp_stb[0] = 4'hF; exp_n = 1;
      for (int d = 0; d < N_DIGITS; d++) ref_disp[d] = ref_seg(dig[4*d +: 4], dpv[d]);
    end else begin
      for (int g = 0; g < N_GROUPS; g++) if (mask[g]) begin
        exp_stb[exp_n] = 4'(1 << g);
        exp_n++;
        for (int j = 0; j < GROUP_DIGITS; j++) begin
          int d;
          d = g * GROUP_DIGITS + j;
          ref_disp[d] = ref_seg(dig[4*d +: 4], dpv[d]);
        end
      end
    end
    n_en = exp_n;
    exp_busy = mode ? N_GROUPS + n_en * (GROUP_DIGITS * 16 * SCK_HALF + STROBE_LEN)
                    : 1 + N_DIGITS * 16 * SCK_HALF + STROBE_LEN;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R9", "busy after request", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      digits = ~dig; dp = ~dpv; group_en = ~mask; lsd_first = ~lsd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(busy_cycles == exp_busy, "R9", "busy length", busy_cycles, exp_busy);
    check(stb_idx == exp_n, "R5/R6", "strobe count", stb_idx, exp_n);
    for (int d = 0; d < N_DIGITS; d++)
      check(mon_disp[d] == ref_disp[d], "R6", "latched digit", mon_disp[d], ref_disp[d]);
  endtask

  initial begin
    for (int d = 0; d < N_DIGITS; d++) begin
      ref_disp[d] = '0;
      mon_disp[d] = '0;
    end
    repeat (3) @(negedge clk);
    check(!busy && !sclk && !sdata && strobe == 4'h0, "R1", "outputs in reset",
          {busy, sclk, sdata, strobe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !sclk && strobe == 4'h0, "R1", "idle after reset",
          {busy, sclk, strobe}, 0);

    // full chain, both orders, rotating codes (all sixteen covered)
    for (int lsd = 0; lsd < 2; lsd++) begin
      for (int off = 0; off < 8; off++) begin
        logic [47:0] dg;
        for (int k = 0; k < N_DIGITS; k++) dg[4*k +: 4] = 4'((off * 3 + k) % 16);
        run(1'b0, lsd[0], 4'h0, dg, 12'(off * 373 + 5), (off == 3));
      end
    end

    // group mode: every mask, both orders
    for (int lsd = 0; lsd < 2; lsd++) begin
      for (int m = 0; m < 16; m++) begin
        logic [47:0] dg;
        for (int k = 0; k < N_DIGITS; k++) dg[4*k +: 4] = 4'((m + k * 5 + lsd * 7) % 16);
        run(1'b1, lsd[0], 4'(m), dg, 12'(m * 291 + lsd), (m == 9));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule